// File: doc/BRIEF.md
# Fixed-Length Radio Packet Framer

This block is the transmit half of a packet handler for a sub-GHz radio link. When it sees a start strobe, it turns one payload held in a byte FIFO into a serial bit stream. The stream begins with an alternating preamble and a network sync word. A length byte follows only in the variable format. Then come an optional node address byte, the message bytes popped from the FIFO, and an optional 16-bit checksum.

The modem paces the stream with a per-bit enable. The framer presents the current bit on `txBit` and moves to the next bit only on cycles where `bitEn` is high. All configuration inputs must be held steady from the start strobe until `done`. If the payload length is illegal for the selected FIFO size, the start is refused and an error flag is raised instead.

Top module: `pkt_framer`

## Requirements
- R1: After reset `busy`, `done`, `err`, `fifoRd` and `txBit` are all low.
- R2: A frame begins with preamble bytes of value 0xAA. The number of preamble bytes is `preambleLen`+1, so the code range 0..3 gives 1 to 4 bytes.
- R3: The sync field follows the preamble and is `syncLen`+1 bytes long. Its bytes are taken from `syncWord`, starting with bits 31:24 and moving toward the low end.
- R4: With `varLen`=0 no length byte is sent. With `varLen`=1 a single byte equal to {0,`payloadLen`} is sent right after the sync field.
- R5: With `addrEn`=1 the `nodeAddr` byte is sent ahead of the message and counts as one byte of `payloadLen`. The number of message bytes is `payloadLen` minus `addrEn`.
- R6: Every byte goes out MSB first. Exactly one bit is consumed per cycle with `bitEn` high. While `bitEn` is low during a frame, `txBit` holds its value.
- R7: `fifoRd` is high for one cycle per message byte. The byte on `fifoData` is taken in that same cycle. No FIFO pop occurs for any other field.
- R8: With `crcEn`=1 two checksum bytes follow the message, high byte first. The checksum is CRC-16 with polynomial 0x1021, initial value 0xFFFF, bits processed MSB first, no final XOR. It covers the address and message bytes only.
- R9: A start with `payloadLen`=0 or `payloadLen` above the FIFO capacity sets `err`, sends no bit and pops nothing. The capacity is 16×(`fifoSize`+1), so codes 0..3 give 16, 32, 48 and 64 bytes. `err` holds until the next start strobe, and an accepted start clears it.
- R10: On the clock edge that consumes the final bit, `busy` falls and `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame; ignored while busy |
| bitEn | input | 1 | Consume one output bit this cycle |
| preambleLen | input | 2 | Preamble bytes minus one |
| syncLen | input | 2 | Sync bytes minus one |
| syncWord | input | 32 | Sync value, sent from the top byte down |
| varLen | input | 1 | 1 = variable format (length byte sent) |
| addrEn | input | 1 | Send node address byte |
| nodeAddr | input | 8 | Node address value |
| crcEn | input | 1 | Append 16-bit checksum |
| payloadLen | input | 7 | Address plus message byte count |
| fifoSize | input | 2 | FIFO capacity code |
| fifoData | input | 8 | Head byte of the payload FIFO |
| fifoRd | output | 1 | Pop the FIFO head this cycle |
| txBit | output | 1 | Serial output bit |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| err | output | 1 | Last start refused for a bad length |

## Verification
The bench goes after the length boundaries. A payload of exactly 16 in a 16-byte FIFO and of 64 in a 64-byte FIFO must be accepted, and 17, 33-in-32 and 0 must be refused. A design with an off-by-one capacity compare either refuses full FIFOs or sends frames that run past the stored data. Another case is an address-only payload. There a decoder that forgets the address counts toward the length would pop a phantom message byte or shift the checksum. Irregular and sparse bit-enable patterns are used to expose designs that advance on every clock instead of per enabled bit, or that drop a bit at byte boundaries. Every frame is compared bit for bit against a model built from the field rules, checksum included.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  // Field order is behaviour: the sequencer walks these in ascending order.
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SYNC, ST_LEN, ST_ADDR, ST_MSG, ST_CRCH, ST_CRCL
  } field_t;

  typedef struct packed {
    logic   load;     // put a new byte into the shifter
    logic   shift;    // consume one bit
    field_t src;      // which field feeds the byte
    logic [1:0] idx;  // byte index within preamble/sync
    logic   crcInit;  // reset the checksum
  } strobe_t;
endpackage

// File: rtl/pkt_framer_ctrl.sv
module pkt_framer_ctrl
  import pkt_framer_pkg::*;
#(
  parameter int LEN_W     = 7,
  parameter int FIFO_STEP = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             bitEn,
  input  logic             lastBit,
  input  logic [1:0]       preambleLen,
  input  logic [1:0]       syncLen,
  input  logic             varLen,
  input  logic             addrEn,
  input  logic             crcEn,
  input  logic [LEN_W-1:0] payloadLen,
  input  logic [1:0]       fifoSize,
  output strobe_t          strb,
  output logic             fifoRd,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int CAP_W = LEN_W + 1;

  field_t           state;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] msgCnt;
  logic [CAP_W-1:0] fifoCap;
  logic             bad;
  field_t           nxt;
  logic [LEN_W-1:0] fieldLast;
  logic             byteEnd;
  logic             more;

  assign msgCnt  = payloadLen - LEN_W'(addrEn);
  assign fifoCap = CAP_W'((int'(fifoSize) + 1) * FIFO_STEP);
  assign bad     = (payloadLen == '0) || ({1'b0, payloadLen} > fifoCap);
  assign busy    = (state != ST_IDLE);
  assign byteEnd = busy && bitEn && lastBit;

  function automatic logic fieldOn(field_t f);
    case (f)
      ST_LEN:            return varLen;
      ST_ADDR:           return addrEn;
      ST_MSG:            return msgCnt != '0;
      ST_CRCH, ST_CRCL:  return crcEn;
      default:           return 1'b1;
    endcase
  endfunction

  // First enabled field after the current one.
  always_comb begin
    nxt = ST_IDLE;
    for (int s = int'(ST_CRCL); s > 0; s--) begin
      if (s > int'(state) && fieldOn(field_t'(s))) nxt = field_t'(s);
    end
  end

  always_comb begin
    case (state)
      ST_PRE:  fieldLast = LEN_W'(preambleLen);
      ST_SYNC: fieldLast = LEN_W'(syncLen);
      ST_MSG:  fieldLast = msgCnt - 1'b1;
      default: fieldLast = '0;
    endcase
  end
  assign more = (idx != fieldLast);

  always_comb begin
    strb       = '0;
    strb.src   = ST_IDLE;
    strb.shift = busy && bitEn;
    if (!busy && start && !bad) begin
      strb.load    = 1'b1;
      strb.src     = ST_PRE;
      strb.crcInit = 1'b1;
    end else if (byteEnd) begin
      if (more) begin
        strb.load = 1'b1;
        strb.src  = state;
        strb.idx  = idx[1:0] + 2'd1;
      end else if (nxt != ST_IDLE) begin
        strb.load = 1'b1;
        strb.src  = nxt;
      end
    end
  end
  assign fifoRd = strb.load && (strb.src == ST_MSG);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      idx   <= '0;
      done  <= 1'b0;
      err   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        err <= bad;
        if (!bad) begin
          state <= ST_PRE;
          idx   <= '0;
        end
      end else if (byteEnd) begin
        if (more) begin
          idx <= idx + 1'b1;
        end else begin
          state <= nxt;
          idx   <= '0;
          if (nxt == ST_IDLE) done <= 1'b1;
        end
      end
    end
  end

  a_r9_bad_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && bad) |=> (!busy && err));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r7_pop_in_msg: assert property (@(posedge clk) disable iff (!rstN)
    fifoRd |=> (state == ST_MSG));
endmodule

// File: rtl/pkt_framer_dp.sv
module pkt_framer_dp
  import pkt_framer_pkg::*;
#(
  parameter int         LEN_W      = 7,
  parameter int         SYNC_BYTES = 4,
  parameter logic [7:0] PRE_PAT    = 8'hAA,
  parameter logic [15:0] CRC_POLY  = 16'h1021,
  parameter logic [15:0] CRC_SEED  = 16'hFFFF
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strb,
  input  logic [7:0]              fifoData,
  input  logic [SYNC_BYTES*8-1:0] syncWord,
  input  logic [7:0]              nodeAddr,
  input  logic [LEN_W-1:0]        payloadLen,
  output logic                    msb,
  output logic                    lastBit
);
  logic [7:0]  shReg;
  logic [2:0]  bitCnt;
  logic [15:0] crc;
  logic [7:0]  byteMux;
  logic [15:0] crcNext;

  always_comb begin
    case (strb.src)
      ST_PRE:  byteMux = PRE_PAT;
      ST_SYNC: byteMux = syncWord[(SYNC_BYTES - 1 - int'(strb.idx)) * 8 +: 8];
      ST_LEN:  byteMux = 8'(payloadLen);
      ST_ADDR: byteMux = nodeAddr;
      ST_MSG:  byteMux = fifoData;
      ST_CRCH: byteMux = crc[15:8];
      ST_CRCL: byteMux = crc[7:0];
      default: byteMux = '0;
    endcase
  end

  always_comb begin
    crcNext = crc;
    for (int b = 7; b >= 0; b--) begin
      if (crcNext[15] ^ byteMux[b]) crcNext = {crcNext[14:0], 1'b0} ^ CRC_POLY;
      else                          crcNext = {crcNext[14:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
      crc    <= CRC_SEED;
    end else begin
      if (strb.load) begin
        shReg  <= byteMux;
        bitCnt <= '0;
      end else if (strb.shift) begin
        shReg  <= {shReg[6:0], 1'b0};
        bitCnt <= bitCnt + 3'd1;
      end
      if (strb.load && strb.crcInit)
        crc <= CRC_SEED;
      else if (strb.load && (strb.src == ST_ADDR || strb.src == ST_MSG))
        crc <= crcNext;
    end
  end

  assign msb     = shReg[7];
  assign lastBit = (bitCnt == 3'd7);

  a_r7_msg_from_fifo: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.src == ST_MSG) |=> (shReg == $past(fifoData)));
  a_r2_pre_pattern: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.src == ST_PRE) |=> (shReg == PRE_PAT));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
#(
  parameter int LEN_W      = 7,
  parameter int SYNC_BYTES = 4,
  parameter int FIFO_STEP  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    bitEn,
  input  logic [1:0]              preambleLen,
  input  logic [1:0]              syncLen,
  input  logic [SYNC_BYTES*8-1:0] syncWord,
  input  logic                    varLen,
  input  logic                    addrEn,
  input  logic [7:0]              nodeAddr,
  input  logic                    crcEn,
  input  logic [LEN_W-1:0]        payloadLen,
  input  logic [1:0]              fifoSize,
  input  logic [7:0]              fifoData,
  output logic                    fifoRd,
  output logic                    txBit,
  output logic                    busy,
  output logic                    done,
  output logic                    err
);
  strobe_t strb;
  logic    msb;
  logic    lastBit;

  pkt_framer_ctrl #(.LEN_W(LEN_W), .FIFO_STEP(FIFO_STEP)) u_ctrl (
    .clk, .rstN, .start, .bitEn, .lastBit, .preambleLen, .syncLen,
    .varLen, .addrEn, .crcEn, .payloadLen, .fifoSize,
    .strb, .fifoRd, .busy, .done, .err
  );

  pkt_framer_dp #(.LEN_W(LEN_W), .SYNC_BYTES(SYNC_BYTES)) u_dp (
    .clk, .rstN, .strb, .fifoData, .syncWord, .nodeAddr, .payloadLen,
    .msb, .lastBit
  );

  assign txBit = busy & msb;

  a_r6_hold_when_idle_en: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !bitEn) |=> (!busy || $stable(txBit)));
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (err && !start) |=> !busy);
endmodule

// File: tb/pkt_framer_test.sv
module pkt_framer_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] pre;
    logic [1:0] syn;
    logic       vl;
    logic       ae;
    logic       ce;
    logic [6:0] len;
    logic [1:0] fsz;
    logic [1:0] pat;
    logic       expErr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'd1,  2'd0, 2'd0, 1'b0},
    '{2'd3, 2'd3, 1'b0, 1'b1, 1'b1, 7'd5,  2'd0, 2'd1, 1'b0},
    '{2'd1, 2'd2, 1'b1, 1'b1, 1'b1, 7'd1,  2'd0, 2'd2, 1'b0},
    '{2'd2, 2'd1, 1'b1, 1'b0, 1'b1, 7'd16, 2'd0, 2'd0, 1'b0},
    '{2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 7'd17, 2'd0, 2'd0, 1'b1},
    '{2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 7'd0,  2'd3, 2'd0, 1'b1},
    '{2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 7'd64, 2'd3, 2'd0, 1'b0},
    '{2'd1, 2'd1, 1'b0, 1'b0, 1'b1, 7'd33, 2'd1, 2'd0, 1'b1},
    '{2'd2, 2'd0, 1'b1, 1'b0, 1'b1, 7'd33, 2'd2, 2'd1, 1'b0}
  };

  logic clk = 0, rstN = 0, start = 0, bitEn = 0;
  logic [1:0] preambleLen = 0, syncLen = 0, fifoSize = 0;
  logic [31:0] syncWord = 32'hD391A55C;
  logic varLen = 0, addrEn = 0, crcEn = 0;
  logic [7:0] nodeAddr = 0;
  logic [6:0] payloadLen = 0;
  logic [7:0] fifoData;
  logic fifoRd, txBit, busy, done, err;

  logic [7:0] mem [64];
  int rdPtr = 0;
  assign fifoData = mem[rdPtr[5:0]];
  always @(posedge clk) if (fifoRd) rdPtr <= rdPtr + 1;

  int checks = 0, failures = 0;
  logic expQ[$];
  logic gotQ[$];
  logic [7:0] lfsr = 8'h5B;

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_framer uut (
    .clk, .rstN, .start, .bitEn, .preambleLen, .syncLen, .syncWord,
    .varLen, .addrEn, .nodeAddr, .crcEn, .payloadLen, .fifoSize,
    .fifoData, .fifoRd, .txBit, .busy, .done, .err
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] crcByte(logic [15:0] c, logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic fb = c[15] ^ d[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  task automatic pushByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) expQ.push_back(b[i]);
  endtask

  task automatic runVec(int v);
    vec_t t = VECS[v];
    int msgN, pops, doneCnt, holdBad, cyc, mism;
    logic [15:0] c;
    logic prevTx;
    logic prevValid;
    bit fin;
    preambleLen = t.pre; syncLen = t.syn; varLen = t.vl; addrEn = t.ae;
    crcEn = t.ce; payloadLen = t.len; fifoSize = t.fsz;
    nodeAddr = 8'h4B + 8'(v);
    syncWord = 32'hD391A55C ^ {24'h0, 8'(v * 17)};
    for (int i = 0; i < 64; i++) mem[i] = 8'(8'h30 + i * 7 + v * 3);
    rdPtr = 0;
    expQ.delete(); gotQ.delete();
    msgN = int'(t.len) - int'(t.ae);
    // Expected stream, built from the field rules (R2..R5, R8)
    for (int i = 0; i <= int'(t.pre); i++) pushByte(8'hAA);
    for (int i = 0; i <= int'(t.syn); i++) pushByte(syncWord[31 - 8*i -: 8]);
    if (t.vl) pushByte({1'b0, t.len});
    c = 16'hFFFF;
    if (t.ae) begin pushByte(nodeAddr); c = crcByte(c, nodeAddr); end
    for (int i = 0; i < msgN; i++) begin pushByte(mem[i]); c = crcByte(c, mem[i]); end
    if (t.ce) begin pushByte(c[15:8]); pushByte(c[7:0]); end

    @(negedge clk); start = 1; bitEn = 0;
    @(negedge clk); start = 0;
    check("R9", $sformatf("vec%0d err", v), int'(err), int'(t.expErr));
    if (t.expErr) begin
      check("R9", $sformatf("vec%0d busy after refused start", v), int'(busy), 0);
      repeat (5) @(negedge clk);
      check("R9", $sformatf("vec%0d err sticky", v), int'(err), 1);
      check("R9", $sformatf("vec%0d no pop on refuse", v), rdPtr, 0);
      return;
    end
    pops = 0; doneCnt = 0; holdBad = 0; cyc = 0; fin = 0; prevValid = 0; prevTx = 0;
    while (!fin && cyc < 20000) begin
      case (t.pat)
        2'd0: bitEn = 1;
        2'd1: bitEn = (cyc % 3 == 2);
        default: begin lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]}; bitEn = lfsr[0] | lfsr[3]; end
      endcase
      #1;
      if (busy) begin
        if (prevValid && txBit != prevTx) holdBad++;
        if (bitEn) begin gotQ.push_back(txBit); prevValid = 0; end
        else begin prevValid = 1; prevTx = txBit; end
        if (fifoRd) pops++;
      end
      @(negedge clk);
      cyc++;
      if (done) begin
        doneCnt++;
        check("R10", $sformatf("vec%0d busy low with done", v), int'(busy), 0);
        bitEn = 0;
        @(negedge clk);
        check("R10", $sformatf("vec%0d done one cycle", v), int'(done), 0);
        fin = 1;
      end
    end
    check("R10", $sformatf("vec%0d done seen", v), doneCnt, 1);
    check("R6", $sformatf("vec%0d bit count", v), gotQ.size(), expQ.size());
    check("R6", $sformatf("vec%0d txBit held on idle enable", v), holdBad, 0);
    mism = 0;
    for (int i = 0; i < expQ.size() && i < gotQ.size(); i++) if (gotQ[i] !== expQ[i]) mism++;
    check(t.ce ? "R8" : "R5", $sformatf("vec%0d stream mismatches (R2 R3 R4)", v), mism, 0);
    check("R7", $sformatf("vec%0d pops", v), pops, msgN);
    check("R9", $sformatf("vec%0d err cleared", v), int'(err), 0);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done", int'(done), 0);
    check("R1", "err", int'(err), 0);
    check("R1", "fifoRd", int'(fifoRd), 0);
    check("R1", "txBit", int'(txBit), 0);
    for (int v = 0; v < NV; v++) runVec(v);
    // Directed: start while busy is ignored, refused start after a good frame
    preambleLen = 0; syncLen = 0; varLen = 0; addrEn = 1; crcEn = 0;
    payloadLen = 1; fifoSize = 0; bitEn = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check("R2", "busy after start", int'(busy), 1);
    check("R2", "first preamble bit is 1", int'(txBit), 1);
    bitEn = 1;
    @(negedge clk);
    check("R6", "second preamble bit is 0", int'(txBit), 0);
    payloadLen = 0; start = 1;
    @(negedge clk); start = 0; payloadLen = 1;
    check("R9", "start while busy does not raise err", int'(err), 0);
    while (busy) @(negedge clk);
    bitEn = 0;
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule